// File: doc/BRIEF.md
# ADC Power-Mode Sequencer

This block sits on the host side of a parallel-output sampling converter and moves it between three power states: running, a light standby that keeps the digital logic and reference alive, and a deep standby in which only leakage remains. The converter selects the standby depth from the level of its chip-select line while its active-low shutdown line is held low. The sequencer drives both lines and orders them so that the converter ends up in the intended state. It then times the wake-up interval, which differs greatly between the two standby depths, before it allows conversions again.

A client asks for a power state with a one-cycle request strobe and a two-bit mode code. A `ready` output is high only when a new conversion may start. The conversion controller shares the chip-select line through a grant: while granted, its chip-select value passes straight to the converter. While it reports a conversion in flight, a shutdown request waits. All intervals are whole clock cycles derived from a clock-frequency parameter and rounded up.

Top module: `adc_pwr_seq`

## Requirements
- R1: During and after reset `adc_shdn_n`=1, `adc_cs_n`=1, `ready`=0 and `cs_grant`=0. `ready` and `cs_grant` rise exactly SLP_CYC clock edges after the first edge with `rst` low, because the reference is assumed cold.
- R2: Mode codes are 2'b00 run, 2'b01 light standby, 2'b10 deep standby. A strobe carrying 2'b11 changes no output and no stored request.
- R3: On entry to light standby, `adc_shdn_n` falls and `adc_cs_n` is driven low on the same edge, and both stay there.
- R4: On entry to deep standby from run or from a wake, `adc_shdn_n` falls with `adc_cs_n` low. `adc_cs_n` rises exactly SET_CYC edges later, and `adc_shdn_n` stays low.
- R5: Going from light to deep standby raises `adc_cs_n` on the accepting edge while `adc_shdn_n` stays low.
- R6: Leaving light standby raises `adc_shdn_n` and `adc_cs_n` on the accepting edge. `ready` and `cs_grant` rise exactly NAP_CYC edges later.
- R7: Leaving deep standby, or leaving a light standby that was entered from deep standby without an intervening completed wake, uses SLP_CYC in place of NAP_CYC.
- R8: A request accepted during a wake or deep-entry countdown is stored, with the latest one winning. It is applied when the countdown ends. A request accepted on the final countdown edge is honoured on that edge, and `ready` does not rise.
- R9: While `conv_busy` is high, an accepted standby request holds `cs_grant` and `adc_shdn_n` high. Shutdown starts on the first edge with `conv_busy` low. A run request accepted in that interval cancels the shutdown and restores `ready`.
- R10: `ready` falls on the very edge that accepts any standby request while running.
- R11: While `cs_grant` is high, `adc_cs_n` equals `conv_cs_n` in the same cycle.
- R12: NAP_CYC = ceil(NAP_WAKE_NS·CLK_HZ/1e9), SET_CYC = ceil(SLEEP_SETUP_NS·CLK_HZ/1e9), SLP_CYC = ceil(SLEEP_WAKE_US·CLK_HZ/1e6), each at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle strobe qualifying `req_mode` |
| req_mode | input | 2 | Requested power state code |
| conv_busy | input | 1 | Conversion controller is mid-conversion and holds chip-select |
| conv_cs_n | input | 1 | Chip-select value from the conversion controller |
| cs_grant | output | 1 | Conversion controller owns chip-select |
| adc_cs_n | output | 1 | Chip-select to the converter, active low |
| adc_shdn_n | output | 1 | Shutdown to the converter, active low |
| ready | output | 1 | A new conversion may be started |

## Verification
Two events can share one clock edge: a new request strobe and the expiry of a running countdown. The bench provokes this by counting cycles from the observed rise of `adc_shdn_n` and placing a standby request on exactly the final wake edge. It judges the result by whether `ready` stays low and whether the shutdown line falls on that edge. A second pairing puts the release of `conv_busy` next to a cancelling run request. Both are judged against a behavioural model that is compared on every clock.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_NAP  = 2'b01;
  localparam logic [1:0] MODE_DEEP = 2'b10;
  localparam logic [1:0] MODE_RSV  = 2'b11;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DRAIN = 3'd1,
    ST_NAP   = 3'd2,
    ST_SETUP = 3'd3,
    ST_DEEP  = 3'd4,
    ST_WAKE  = 3'd5
  } pwr_state_e;

  // cycles = ceil(amount * clk_hz / per_sec), never below one
  function automatic longint ceil_cycles(longint amount, longint per_sec, longint clk_hz);
    longint c;
    c = (amount * clk_hz + per_sec - 1) / per_sec;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/adc_pwr_reqlatch.sv
module adc_pwr_reqlatch
  import adc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  output logic       accept,
  output logic [1:0] want
);

  logic [1:0] held_q;

  assign accept = req_valid && (req_mode != MODE_RSV);
  assign want   = accept ? req_mode : held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= MODE_RUN;
    else if (accept) held_q <= req_mode;
  end

  // R2: a reserved code leaves the stored request untouched
  p_rsv_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == MODE_RSV) |=> (held_q == $past(held_q)));

endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  localparam logic [CW-1:0] RV  = CW'(RST_VAL);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= RV;
    else if (load) cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign done = (cnt_q == ONE);

  // R12: a countdown is never started at zero
  p_load_nonzero_r12: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

  // R12: after done the counter has run out
  p_done_then_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !done);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter longint CLK_HZ         = 50_000_000,
  parameter int     NAP_WAKE_NS    = 200,
  parameter int     SLEEP_SETUP_NS = 10,
  parameter int     SLEEP_WAKE_US  = 160_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       conv_busy,
  input  logic       conv_cs_n,
  output logic       cs_grant,
  output logic       adc_cs_n,
  output logic       adc_shdn_n,
  output logic       ready
);

  localparam int NAP_CYC = int'(ceil_cycles(longint'(NAP_WAKE_NS), 64'd1_000_000_000, CLK_HZ));
  localparam int SET_CYC = int'(ceil_cycles(longint'(SLEEP_SETUP_NS), 64'd1_000_000_000, CLK_HZ));
  localparam int SLP_CYC = int'(ceil_cycles(longint'(SLEEP_WAKE_US), 64'd1_000_000, CLK_HZ));
  localparam int MAX_CYC = (SLP_CYC > NAP_CYC) ?
                           ((SLP_CYC > SET_CYC) ? SLP_CYC : SET_CYC) :
                           ((NAP_CYC > SET_CYC) ? NAP_CYC : SET_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] NAP_V = CW'(NAP_CYC);
  localparam logic [CW-1:0] SET_V = CW'(SET_CYC);
  localparam logic [CW-1:0] SLP_V = CW'(SLP_CYC);

  pwr_state_e    state_q, state_d;
  logic          shdn_q, shdn_d;
  logic          own_q, own_d;
  logic          rdy_q, rdy_d;
  logic          gnt_q, gnt_d;
  logic          deep_q, deep_d;
  logic          tm_load;
  logic [CW-1:0] tm_val;
  logic          tm_done;
  logic          accept;
  logic [1:0]    want;

  adc_pwr_reqlatch u_req (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .accept    (accept),
    .want      (want)
  );

  adc_pwr_timer #(.CW(CW), .RST_VAL(SLP_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tm_load),
    .load_val (tm_val),
    .done     (tm_done)
  );

  always_comb begin
    state_d = state_q;
    shdn_d  = shdn_q;
    own_d   = own_q;
    rdy_d   = rdy_q;
    gnt_d   = gnt_q;
    deep_d  = deep_q;
    tm_load = 1'b0;
    tm_val  = SET_V;
    unique case (state_q)
      ST_RUN: begin
        if (want != MODE_RUN) begin
          rdy_d   = 1'b0;
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (want == MODE_RUN) begin
          rdy_d   = 1'b1;
          state_d = ST_RUN;
        end else if (!conv_busy) begin
          gnt_d  = 1'b0;
          shdn_d = 1'b0;
          own_d  = 1'b0;
          if (want == MODE_NAP) begin
            state_d = ST_NAP;
          end else begin
            state_d = ST_SETUP;
            tm_load = 1'b1;
            tm_val  = SET_V;
          end
        end
      end
      ST_NAP: begin
        if (want == MODE_RUN) begin
          shdn_d  = 1'b1;
          own_d   = 1'b1;
          state_d = ST_WAKE;
          tm_load = 1'b1;
          tm_val  = deep_q ? SLP_V : NAP_V;
        end else if (want == MODE_DEEP) begin
          own_d   = 1'b1;
          deep_d  = 1'b1;
          state_d = ST_DEEP;
        end
      end
      ST_SETUP: begin
        if (tm_done) begin
          own_d   = 1'b1;
          deep_d  = 1'b1;
          state_d = ST_DEEP;
        end
      end
      ST_DEEP: begin
        if (want == MODE_RUN) begin
          shdn_d  = 1'b1;
          state_d = ST_WAKE;
          tm_load = 1'b1;
          tm_val  = SLP_V;
        end else if (want == MODE_NAP) begin
          own_d   = 1'b0;
          state_d = ST_NAP;
        end
      end
      ST_WAKE: begin
        if (tm_done) begin
          deep_d = 1'b0;
          if (want == MODE_RUN) begin
            rdy_d   = 1'b1;
            gnt_d   = 1'b1;
            state_d = ST_RUN;
          end else begin
            shdn_d = 1'b0;
            own_d  = 1'b0;
            if (want == MODE_NAP) begin
              state_d = ST_NAP;
            end else begin
              state_d = ST_SETUP;
              tm_load = 1'b1;
              tm_val  = SET_V;
            end
          end
        end
      end
      default: state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAKE;
      shdn_q  <= 1'b1;
      own_q   <= 1'b1;
      rdy_q   <= 1'b0;
      gnt_q   <= 1'b0;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shdn_q  <= shdn_d;
      own_q   <= own_d;
      rdy_q   <= rdy_d;
      gnt_q   <= gnt_d;
      deep_q  <= deep_d;
    end
  end

  assign ready      = rdy_q;
  assign cs_grant   = gnt_q;
  assign adc_shdn_n = shdn_q;
  assign adc_cs_n   = gnt_q ? conv_cs_n : own_q;

  // cycles spent with shutdown released, saturating
  localparam int AW = $clog2(NAP_CYC + 1);
  localparam logic [AW-1:0] AWAKE_MAX = AW'(NAP_CYC);
  logic [AW-1:0] awake_q;
  always_ff @(posedge clk) begin
    if (rst || !shdn_q) awake_q <= '0;
    else if (awake_q != AWAKE_MAX) awake_q <= awake_q + AW'(1);
  end

  // R6: ready only rises after the shortest wake interval
  p_wake_window_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> (int'(awake_q) >= NAP_CYC - 1));

  // R10: a standby request accepted while running drops ready at once
  p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && accept && req_mode != MODE_RUN) |=> !rdy_q);

  // R4: chip-select rises in standby only when shutdown was already low
  p_deep_order_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(own_q) |-> $past(!shdn_q));

  // R3: shutdown always falls with chip-select held low
  p_shdn_cs_low_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(shdn_q) |-> !own_q);

  // R11: the conversion controller is granted only while powered
  p_grant_awake_r11: assert property (@(posedge clk) disable iff (rst)
    (gnt_q || rdy_q) |-> shdn_q);

endmodule

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;

  // 50 MHz: 190 ns -> ceil(9.5)=10, 30 ns -> ceil(1.5)=2, 100 us -> 5000
  localparam int NAP_E = (190 * 50 + 999) / 1000;
  localparam int SET_E = (30 * 50 + 999) / 1000;
  localparam int SLP_E = 100 * 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic conv_busy = 1'b0;
  logic conv_cs_n = 1'b1;
  logic cs_grant, adc_cs_n, adc_shdn_n, ready;

  always #10 clk = ~clk;

  adc_pwr_seq #(
    .CLK_HZ(50_000_000), .NAP_WAKE_NS(190), .SLEEP_SETUP_NS(30), .SLEEP_WAKE_US(100)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .conv_busy(conv_busy), .conv_cs_n(conv_cs_n), .cs_grant(cs_grant),
    .adc_cs_n(adc_cs_n), .adc_shdn_n(adc_shdn_n), .ready(ready)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference: phase 0 run,1 drain,2 nap,3 deep-entry,4 deep,5 wake
  int ph, left, pend;
  bit deep, e_shdn, e_own, e_rdy, e_gnt;

  always @(posedge clk) begin
    if (rst) begin
      ph = 5; left = SLP_E; pend = 0; deep = 0;
      e_shdn = 1; e_own = 1; e_rdy = 0; e_gnt = 0;
    end else begin
      if (req_valid && req_mode != 2'b11) pend = req_mode;
      case (ph)
        0: if (pend != 0) begin e_rdy = 0; ph = 1; end
        1: if (pend == 0) begin e_rdy = 1; ph = 0; end
           else if (!conv_busy) begin
             e_gnt = 0; e_shdn = 0; e_own = 0; left = SET_E;
             ph = (pend == 1) ? 2 : 3;
           end
        2: if (pend == 0) begin e_shdn = 1; e_own = 1; ph = 5; left = deep ? SLP_E : NAP_E; end
           else if (pend == 2) begin e_own = 1; deep = 1; ph = 4; end
        3: if (left == 1) begin e_own = 1; deep = 1; ph = 4; end else left--;
        4: if (pend == 0) begin e_shdn = 1; ph = 5; left = SLP_E; end
           else if (pend == 1) begin e_own = 0; ph = 2; end
        5: if (left == 1) begin
             deep = 0;
             if (pend == 0) begin e_rdy = 1; e_gnt = 1; ph = 0; end
             else begin e_shdn = 0; e_own = 0; left = SET_E; ph = (pend == 1) ? 2 : 3; end
           end else left--;
        default: ;
      endcase
    end
  end

  task automatic chk(string t, int act, int exp_v, string what);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", t, what, act, exp_v, cyc);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // advance one clock and compare every output against the model
  task automatic step();
    @(negedge clk);
    chk(tag, int'(adc_shdn_n), int'(e_shdn), "adc_shdn_n");
    chk(tag, int'(ready), int'(e_rdy), "ready");
    chk(tag, int'(cs_grant), int'(e_gnt), "cs_grant");
    chk(tag, int'(adc_cs_n), int'(e_gnt ? conv_cs_n : e_own), "adc_cs_n");
  endtask

  task automatic req(logic [1:0] m);
    req_valid = 1'b1; req_mode = m;
    step();
    req_valid = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 20000) begin step(); n++; end
  endtask

  task automatic wait_shdn_high();
    for (int i = 0; i < 20 && !adc_shdn_n; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      report();
    end
  end

  initial begin
    int n;
    // R1: reset state
    tag = "R1";
    step(); step();
    chk("R1", int'(adc_shdn_n), 1, "shdn in reset");
    chk("R1", int'(adc_cs_n), 1, "cs in reset");
    chk("R1", int'(ready), 0, "ready in reset");
    rst = 1'b0;
    wait_ready(n);
    chk("R1", n, SLP_E, "cycles from reset to ready");

    // R11: chip-select passes through while granted
    tag = "R11";
    conv_cs_n = 1'b0; step();
    chk("R11", int'(adc_cs_n), 0, "cs follows controller");
    conv_cs_n = 1'b1; step();
    chk("R11", int'(adc_cs_n), 1, "cs follows controller");

    // R10 and R3: light standby entry
    tag = "R10";
    req(2'b01);
    chk("R10", int'(ready), 0, "ready on accept edge");
    chk("R10", int'(adc_shdn_n), 1, "shdn still high while draining");
    tag = "R3";
    step();
    chk("R3", int'(adc_shdn_n), 0, "shdn in nap");
    chk("R3", int'(adc_cs_n), 0, "cs in nap");
    repeat (3) step();

    // R6 and R12: wake from light standby
    tag = "R6";
    req(2'b00);
    wait_shdn_high();
    chk("R6", int'(adc_cs_n), 1, "cs high during wake");
    wait_ready(n);
    chk("R6", n, NAP_E, "nap wake cycles");
    chk("R12", n, 10, "rounded-up nap count");

    // R4: deep standby entry from run
    tag = "R4";
    req(2'b10);
    step();
    chk("R4", int'(adc_shdn_n), 0, "shdn low first");
    chk("R4", int'(adc_cs_n), 0, "cs low with shdn");
    n = 0;
    while (adc_cs_n == 1'b0 && n < 20) begin step(); n++; end
    chk("R4", n, SET_E, "setup cycles before cs rises");
    chk("R4", int'(adc_shdn_n), 0, "shdn stays low in sleep");

    // R2: reserved code ignored
    tag = "R2";
    req(2'b11);
    repeat (4) step();
    chk("R2", int'(adc_shdn_n), 0, "shdn after reserved code");
    chk("R2", int'(adc_cs_n), 1, "cs after reserved code");

    // R7: wake from deep standby
    tag = "R7";
    req(2'b00);
    wait_shdn_high();
    wait_ready(n);
    chk("R7", n, SLP_E, "sleep wake cycles");

    // R5: light to deep standby
    tag = "R5";
    req(2'b01); step(); step();
    req(2'b10);
    chk("R5", int'(adc_cs_n), 1, "cs rises nap to sleep");
    chk("R5", int'(adc_shdn_n), 0, "shdn stays low");

    // R7: light standby entered from deep keeps the long wake
    tag = "R7";
    req(2'b01);
    chk("R7", int'(adc_cs_n), 0, "cs low sleep to nap");
    step();
    req(2'b00);
    wait_shdn_high();
    wait_ready(n);
    chk("R7", n, SLP_E, "wake after sleep then nap");

    // R8: queued requests and a request on the final wake edge
    tag = "R8";
    req(2'b01); step(); step();
    req(2'b00);
    wait_shdn_high();
    req(2'b10);
    for (int i = 0; i < NAP_E - 2; i++) step();
    req(2'b01);
    chk("R8", int'(ready), 0, "ready held on collision");
    chk("R8", int'(adc_shdn_n), 0, "shdn falls on final edge");
    chk("R8", int'(adc_cs_n), 0, "last request wins (nap)");
    repeat (4) step();
    chk("R8", int'(adc_cs_n), 0, "cs stays low in nap");

    // R9: busy holds off shutdown; cancel while draining
    tag = "R9";
    req(2'b00);
    wait_shdn_high();
    wait_ready(n);
    conv_busy = 1'b1;
    req(2'b01);
    repeat (3) step();
    chk("R9", int'(cs_grant), 1, "grant held while busy");
    chk("R9", int'(adc_shdn_n), 1, "shdn held while busy");
    conv_busy = 1'b0;
    step();
    chk("R9", int'(adc_shdn_n), 0, "shdn after busy release");
    req(2'b00);
    wait_shdn_high();
    wait_ready(n);
    conv_busy = 1'b1;
    req(2'b10);
    step();
    conv_busy = 1'b0;
    req(2'b00);
    chk("R9", int'(ready), 1, "cancel restores ready");
    chk("R9", int'(adc_shdn_n), 1, "cancel keeps power");
    repeat (4) step();

    report();
  end

endmodule